// File: doc/BRIEF.md
# Codec Serial Link Sample Data Path

This block moves telecom and audio samples between a processor bus and a serial codec link. Each of the two channels has a transmit queue and a receive queue. Each queue is a fall-through shift register: a value enters at the top slot and falls one slot per cycle until it rests on the lowest occupied slot. The bus reaches the queues through one data register per channel. A write enqueues a sample into that channel's transmit queue. A read returns the bottom entry of the channel's receive queue and pops it.

When the frame sync pulse is sampled, the transmit side pops the bottom entry of each transmit queue. It places the two values into fixed slots of a 64-bit frame and shifts that frame out MSB first over the next 64 cycles (subframe 0). The receive side samples the incoming line on the falling clock edge over the same 64 cycles. After the last bit it pushes the two slots into the receive queues.

Status flags are plain levels with no interrupt. They show empty and full for every queue, a sticky underrun flag per transmit queue and a sticky overrun flag per receive queue. Samples are left-justified in 16 bits: telecom uses bits 15:2 and audio uses bits 15:4.

Top module: `codec_link_datapath`

## Requirements
- R1: After reset, all four queues report empty and not full, the underrun and overrun flags are clear, `sdout` is 0 and `bus_rdata` is 0.
- R2: A bus write with `bus_sel` 0 (telecom) or 1 (audio) enqueues `bus_wdata[15:0]` into that channel's transmit queue. The write is accepted when the queue is not full, or when it is popped in the same cycle; otherwise it is dropped.
- R3: Each queue holds 8 entries in first-in first-out order. Empty means no slot is occupied, full means all 8 slots are occupied, and the two are never set together.
- R4: When `frame_sync` is sampled high at a rising edge, `sdout` carries the 64-bit frame MSB first during the following 64 cycles. Frame bit 63 comes first. The telecom sample sits in bits 63:48, the audio sample in bits 47:32, and bits 31:0 are zero. Outside a frame `sdout` is 0.
- R5: The frame load pops the bottom entry of each transmit queue. If that bottom slot is not occupied, the channel's slot is all zeros and its sticky `tx_underrun` bit (bit 0 telecom, bit 1 audio) is set.
- R6: `sdin` is sampled on the falling edge in each of those 64 cycles. After the 64th bit, frame bits 63:48 are pushed to the telecom receive queue and bits 47:32 to the audio receive queue.
- R7: A receive push into a full queue is discarded, the queue contents are unchanged, and the channel's sticky `rx_overrun` bit is set.
- R8: `bus_rdata[15:0]` shows the bottom receive entry of the channel selected by `bus_sel`. A bus read pops it at the clock edge and the remaining entries move down one slot. The data is 0 when the bottom slot is not occupied.
- R9: Telecom samples keep all 16 bits in both directions, including bits 1:0. Audio bits 3:0 are transmitted as written but read back as 0.
- R10: Bits 31:16 of `bus_wdata` have no effect, and bits 31:16 of `bus_rdata` are always 0.
- R11: A bus write and a frame pop on the same transmit queue in the same cycle both take effect. A bus read and a frame-end push on the same receive queue in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; serial bits change on rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Channel select: 0 telecom, 1 audio |
| bus_wr | input | 1 | Write strobe for the selected transmit queue |
| bus_wdata | input | 32 | Write data; sample in bits 15:0 |
| bus_rd | input | 1 | Read strobe; pops the selected receive queue |
| bus_rdata | output | 32 | Bottom receive entry of the selected channel |
| frame_sync | input | 1 | Pulse marking frame bit 63 of subframe 0 |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| tx_empty | output | 2 | Transmit queue empty, bit per channel |
| tx_full | output | 2 | Transmit queue full, bit per channel |
| rx_empty | output | 2 | Receive queue empty, bit per channel |
| rx_full | output | 2 | Receive queue full, bit per channel |
| tx_underrun | output | 2 | Sticky frame load from an empty bottom slot |
| rx_overrun | output | 2 | Sticky push into a full receive queue |

## Verification
Two pairs of events can fall in the same cycle:
- the frame load pops a transmit queue while the bus writes into it;
- the frame-end push fills a receive queue while the bus pops it.

The bench provokes both collisions:
- It raises `bus_wr` in the very cycle `frame_sync` is sampled. It then checks that the older value goes out in that frame and that the new value goes out in the next one.
- It holds `bus_rd` across the edge that ends a frame. It then checks that the read returns the older entry and that the freshly pushed sample is still at the bottom afterwards.

// File: rtl/codec_link_pkg.sv
`timescale 1ns/1ps
// Shared constants for the codec link data path: frame geometry, channel
// numbering and per-channel slot placement. Assumes channels are packed
// from the frame MSB downward, one sample width per channel.
package codec_link_pkg;
    localparam int FRAME_W    = 64;
    localparam int SAMPLE_W   = 16;
    localparam int NUM_CH     = 2;
    localparam int FIFO_DEPTH = 8;
    localparam int BUS_W      = 32;
    localparam int CH_TEL     = 0;
    localparam int CH_AUD     = 1;
    localparam int AUD_PAD    = 4;

    // Most significant frame bit of the slot owned by a channel.
    function automatic int slot_msb(input int ch, input int frame_w, input int sample_w);
        return frame_w - 1 - ch * sample_w;
    endfunction

    // Number of low sample bits forced to zero on the receive side.
    function automatic int rx_zero_lsbs(input int ch);
        return (ch == CH_AUD) ? AUD_PAD : 0;
    endfunction
endpackage

// File: rtl/bubble_fifo.sv
`timescale 1ns/1ps
// Fall-through shift-register queue. A value enters the top slot and moves
// down one slot per cycle while the slot beneath it is free; a pop clears the
// bottom slot and lets every occupied slot above move down in the same cycle.
// Assumes pop is only honoured when the bottom slot is occupied.
module bubble_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    output logic             push_ok,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             head_valid,
    output logic             empty,
    output logic             full
);
    localparam int TOP = DEPTH - 1;

    logic [DEPTH-1:0] slot_valid;
    logic [WIDTH-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0] moves;   // slot i hands its entry down (or out) this cycle
    logic [DEPTH-1:0] frees;   // slot i can accept an entry this cycle

    // Ripple the free/move chain from the bottom slot upward.
    always_comb begin
        moves[0] = pop & slot_valid[0];
        frees[0] = ~slot_valid[0] | moves[0];
        for (int i = 1; i < DEPTH; i++) begin
            moves[i] = slot_valid[i] & frees[i-1];
            frees[i] = ~slot_valid[i] | moves[i];
        end
    end

    assign push_ok    = push & frees[TOP];
    assign head_data  = slot_data[0];
    assign head_valid = slot_valid[0];
    assign empty      = ~|slot_valid;
    assign full       = &slot_valid;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic             fill;
        logic [WIDTH-1:0] fill_data;
        if (g == TOP) begin : g_top
            assign fill      = push_ok;
            assign fill_data = push_data;
        end else begin : g_mid
            assign fill      = moves[g+1];
            assign fill_data = slot_data[g+1];
        end

        // Update one slot: take an entry from above, keep, or vacate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_valid[g] <= 1'b0;
                slot_data[g]  <= '0;
            end else begin
                slot_valid[g] <= fill | (slot_valid[g] & ~moves[g]);
                if (fill) begin
                    slot_data[g] <= fill_data;
                end
            end
        end
    end
endmodule

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
// Transmit frame shifter. On load it captures a whole frame and then drives
// it MSB first for FRAME_W cycles; the line is held low when idle.
// Assumes load is a single-cycle pulse; a load during a frame restarts it.
module frame_tx #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    output logic               sdout,
    output logic               active
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;

    // Load, shift and end-of-frame control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            active  <= 1'b0;
        end else if (load) begin
            shreg   <= load_word;
            bit_cnt <= '0;
            active  <= 1'b1;
        end else if (active) begin
            if (bit_cnt == LAST) begin
                active <= 1'b0;
            end else begin
                shreg   <= shreg << 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign sdout = active & shreg[FRAME_W-1];
endmodule

// File: rtl/frame_rx.sv
`timescale 1ns/1ps
// Receive frame shifter. The line is sampled on the falling edge; that bit is
// shifted in on the following rising edge for FRAME_W cycles after start.
// On the last bit a one-cycle push strobe presents the assembled frame.
// Assumes start marks the same edge the transmit side loads on.
module frame_rx #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               sdin,
    output logic               push,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic               line_bit;
    logic [FRAME_W-2:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               active;

    // Capture the line half a cycle after the transmit edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            line_bit <= 1'b0;
        end else begin
            line_bit <= sdin;
        end
    end

    // Shift captured bits in and count the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            active  <= 1'b0;
        end else if (start) begin
            bit_cnt <= '0;
            active  <= 1'b1;
        end else if (active) begin
            shreg   <= {shreg[FRAME_W-3:0], line_bit};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST) begin
                active <= 1'b0;
            end
        end
    end

    assign push    = active & (bit_cnt == LAST);
    assign rx_word = {shreg, line_bit};
endmodule

// File: rtl/codec_link_datapath.sv
`timescale 1ns/1ps
// Codec link sample data path: per-channel transmit and receive fall-through
// queues behind bus data registers, a frame shifter that loads fixed slots at
// frame sync, and a receive shifter that unloads them at frame end.
// Assumes frame_sync pulses are at least FRAME_W cycles apart.
module codec_link_datapath
    import codec_link_pkg::*;
#(
    parameter int NCH    = NUM_CH,
    parameter int SMP_W  = SAMPLE_W,
    parameter int FRM_W  = FRAME_W,
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int DATA_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_sync,
    input  logic              sdin,
    output logic              sdout,
    output logic [NCH-1:0]    tx_empty,
    output logic [NCH-1:0]    tx_full,
    output logic [NCH-1:0]    rx_empty,
    output logic [NCH-1:0]    rx_full,
    output logic [NCH-1:0]    tx_underrun,
    output logic [NCH-1:0]    rx_overrun
);
    localparam int PAD_W = FRM_W - NCH * SMP_W;

    logic [FRM_W-1:0] frame_word;
    logic [FRM_W-1:0] rx_word;
    logic             rx_push;
    logic             tx_active;
    logic [NCH-1:0]   tx_pop_vec;
    logic [NCH-1:0]   rx_pop_vec;
    logic [NCH-1:0]   rx_push_ok;
    logic [NCH-1:0]   underrun_set;
    logic [NCH-1:0]   overrun_set;
    logic [SMP_W-1:0] rx_head [NCH];
    logic [NCH-1:0]   rx_head_valid;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[DATA_W-1:SMP_W], rx_word[PAD_W-1:0]};
    assign frame_word[PAD_W-1:0] = '0;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int MSB = slot_msb(ch, FRM_W, SMP_W);
        localparam logic [SMP_W-1:0] KEEP = {SMP_W{1'b1}} << rx_zero_lsbs(ch);

        logic             sel_me;
        logic             tx_push_ok;
        logic [SMP_W-1:0] tx_head;
        logic             tx_head_valid;

        assign sel_me = (bus_sel == 1'(ch));

        bubble_fifo #(.WIDTH(SMP_W), .DEPTH(DEPTH)) tx_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (bus_wr & sel_me),
            .push_data (bus_wdata[SMP_W-1:0]),
            .push_ok   (tx_push_ok),
            .pop       (tx_pop_vec[ch]),
            .head_data (tx_head),
            .head_valid(tx_head_valid),
            .empty     (tx_empty[ch]),
            .full      (tx_full[ch])
        );

        bubble_fifo #(.WIDTH(SMP_W), .DEPTH(DEPTH)) rx_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (rx_push),
            .push_data (rx_word[MSB -: SMP_W] & KEEP),
            .push_ok   (rx_push_ok[ch]),
            .pop       (rx_pop_vec[ch]),
            .head_data (rx_head[ch]),
            .head_valid(rx_head_valid[ch]),
            .empty     (rx_empty[ch]),
            .full      (rx_full[ch])
        );

        assign tx_pop_vec[ch]   = frame_sync & tx_head_valid;
        assign underrun_set[ch] = frame_sync & ~tx_head_valid;
        assign rx_pop_vec[ch]   = bus_rd & sel_me & rx_head_valid[ch];
        assign overrun_set[ch]  = rx_push & ~rx_push_ok[ch];
        assign frame_word[MSB -: SMP_W] = tx_head_valid ? tx_head : '0;

        logic unused_wr_ok;
        assign unused_wr_ok = tx_push_ok;
    end

    frame_tx #(.FRAME_W(FRM_W)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_sync),
        .load_word(frame_word),
        .sdout    (sdout),
        .active   (tx_active)
    );

    frame_rx #(.FRAME_W(FRM_W)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (frame_sync),
        .sdin   (sdin),
        .push   (rx_push),
        .rx_word(rx_word)
    );

    // Keep the error flags set once raised until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_underrun <= '0;
            rx_overrun  <= '0;
        end else begin
            tx_underrun <= tx_underrun | underrun_set;
            rx_overrun  <= rx_overrun | overrun_set;
        end
    end

    // Present the selected receive head, zero when its bottom slot is empty.
    always_comb begin
        logic [SMP_W-1:0] pick;
        pick = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (bus_sel == 1'(ch) && rx_head_valid[ch]) begin
                pick = rx_head[ch];
            end
        end
        bus_rdata = {{(DATA_W - SMP_W){1'b0}}, pick};
    end
endmodule

// File: rtl/codec_link_checker.sv
`timescale 1ns/1ps
// Property checker for the codec link data path, attached by bind. It only
// observes; it assumes the bound instance uses the default channel layout.
module codec_link_checker #(
    parameter int NCH    = 2,
    parameter int SMP_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sdout,
    input logic              tx_active,
    input logic              rx_push,
    input logic [NCH-1:0]    tx_pop_vec,
    input logic [NCH-1:0]    rx_pop_vec,
    input logic [NCH-1:0]    tx_empty,
    input logic [NCH-1:0]    tx_full,
    input logic [NCH-1:0]    rx_empty,
    input logic [NCH-1:0]    rx_full,
    input logic [NCH-1:0]    tx_underrun,
    input logic [NCH-1:0]    rx_overrun
);
    assert_read_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:SMP_W] == '0);

    assert_audio_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> bus_rdata[3:0] == 4'h0);

    assert_idle_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !sdout);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(tx_empty[ch] && tx_full[ch]) && !(rx_empty[ch] && rx_full[ch]));

        assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_empty[ch] && bus_sel == 1'(ch)) |-> bus_rdata == '0);

        assert_underrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tx_underrun[ch] |=> tx_underrun[ch]);

        assert_overrun_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_full[ch] && rx_push && !rx_pop_vec[ch]) |=> rx_overrun[ch] && rx_full[ch]);

        assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_full[ch] && !tx_pop_vec[ch]) |=> tx_full[ch]);
    end
endmodule

bind codec_link_datapath codec_link_checker #(
    .NCH   (NCH),
    .SMP_W (SMP_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_rdata  (bus_rdata),
    .sdout      (sdout),
    .tx_active  (tx_active),
    .rx_push    (rx_push),
    .tx_pop_vec (tx_pop_vec),
    .rx_pop_vec (rx_pop_vec),
    .tx_empty   (tx_empty),
    .tx_full    (tx_full),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .tx_underrun(tx_underrun),
    .rx_overrun (rx_overrun)
);

// File: tb/codec_link_datapath_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked in loopback, then directed tests
// for reset, underrun, same-cycle collisions, full transmit and overrun.
module codec_link_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        frame_sync = 1'b0;
    logic        sdin;
    logic        sdout;
    logic [1:0]  tx_empty, tx_full, rx_empty, rx_full, tx_underrun, rx_overrun;
    logic        loopback = 1'b1;
    logic        bench_bit = 1'b0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;
    assign sdin = loopback ? sdout : bench_bit;

    codec_link_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .frame_sync(frame_sync), .sdin(sdin), .sdout(sdout),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
        .rx_full(rx_full), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
    );

    // Each entry: telecom write word in 63:32, audio write word in 31:0.
    localparam logic [63:0] VECS [6] = '{
        64'h0000_A5A7_0000_5A5F,
        64'hFFFF_8001_1234_FFFF,
        64'h0000_0000_0000_0000,
        64'h0000_FFFF_0000_FFFF,
        64'hDEAD_7FFC_BEEF_8008,
        64'h0000_1236_0000_0ABC
    };

    task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic sel, input logic [31:0] w);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = w;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [31:0] v);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_sel = sel;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // One frame: optional write in the sync cycle, optional read across frame end.
    task automatic send_frame(input bit lb, input logic [63:0] rxw, input bit wr_sync,
                              input logic [31:0] wr_val, input bit rd_last,
                              output logic [63:0] got, output logic [31:0] rd_val);
        rd_val = '0;
        got = '0;
        @(posedge clk); #1;
        frame_sync = 1'b1; loopback = lb;
        if (wr_sync) begin bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = wr_val; end
        @(posedge clk); #1;
        frame_sync = 1'b0; bus_wr = 1'b0;
        for (int k = 0; k < 64; k++) begin
            bench_bit = rxw[63-k];
            if (rd_last && k == 63) begin bus_rd = 1'b1; bus_sel = 1'b0; end
            @(negedge clk);
            got[63-k] = sdout;
            if (rd_last && k == 63) rd_val = bus_rdata;
            @(posedge clk); #1;
        end
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog got=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic [31:0] rv, dummy;
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(1);
        // R1 reset state
        check(tx_empty == 2'b11 && rx_empty == 2'b11, "R1 empty", {tx_empty, rx_empty}, 4'hF);
        check(tx_full == 0 && rx_full == 0, "R1 full", {tx_full, rx_full}, 0);
        check(tx_underrun == 0 && rx_overrun == 0, "R1 sticky", {tx_underrun, rx_overrun}, 0);
        check(sdout == 1'b0 && bus_rdata == 0, "R1 outputs", {sdout, bus_rdata}, 0);

        // Vector table in loopback: R2 R4 R6 R8 R9 R10
        foreach (VECS[i]) begin
            logic [15:0] tel, aud;
            tel = VECS[i][47:32];
            aud = VECS[i][15:0];
            bus_write(1'b0, VECS[i][63:32]);
            bus_write(1'b1, VECS[i][31:0]);
            wait_cycles(10);
            send_frame(1'b1, '0, 1'b0, '0, 1'b0, got, dummy);
            check(got == {tel, aud, 32'h0}, "R4 R10 frame slots", got, {tel, aud, 32'h0});
            wait_cycles(10);
            bus_read(1'b0, rv);
            check(rv == {16'h0, tel}, "R6 R9 telecom readback", rv, {16'h0, tel});
            bus_read(1'b1, rv);
            check(rv == {16'h0, aud[15:4], 4'h0}, "R9 R10 audio readback", rv, {16'h0, aud[15:4], 4'h0});
            check(rx_empty == 2'b11 && tx_empty == 2'b11, "R3 R8 drained", {rx_empty, tx_empty}, 4'hF);
        end
        check(tx_underrun == 2'b00, "R5 no underrun yet", tx_underrun, 0);

        // R5 underrun: frame from empty queues sends zero slots
        send_frame(1'b1, '0, 1'b0, '0, 1'b0, got, dummy);
        check(got == 64'h0, "R5 zero slots", got, 0);
        check(tx_underrun == 2'b11, "R5 underrun flag", tx_underrun, 2'b11);
        wait_cycles(10);
        bus_read(1'b0, rv); bus_read(1'b1, rv);
        check(rx_empty == 2'b11, "R8 pop empties", rx_empty, 2'b11);

        // R11 collisions: write during frame load, read during frame-end push
        bus_write(1'b0, 32'h0000_1111);
        wait_cycles(10);
        send_frame(1'b1, '0, 1'b1, 32'h0000_2222, 1'b0, got, dummy);
        check(got[63:48] == 16'h1111, "R11 load takes older", got[63:48], 16'h1111);
        wait_cycles(10);
        send_frame(1'b1, '0, 1'b0, '0, 1'b1, got, rv);
        check(got[63:48] == 16'h2222, "R11 write accepted in load cycle", got[63:48], 16'h2222);
        check(rv == 32'h1111, "R11 read at push edge", rv, 32'h1111);
        wait_cycles(10);
        bus_read(1'b0, rv);
        check(rv == 32'h2222, "R11 push kept after read", rv, 32'h2222);
        bus_read(1'b1, rv); bus_read(1'b1, rv);
        check(rx_empty == 2'b11 && tx_empty == 2'b11, "R11 drained", {rx_empty, tx_empty}, 4'hF);

        // R2 R3 full transmit queue: nine back-to-back writes, ninth dropped
        @(posedge clk); #1;
        for (int j = 0; j < 9; j++) begin
            bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 32'h1000 + 32'(j * 32'h0111);
            @(posedge clk); #1;
        end
        bus_wr = 1'b0;
        wait_cycles(10);
        check(tx_full[0] == 1'b1, "R3 tx full", tx_full, 2'b01);
        for (int j = 0; j < 8; j++) begin
            logic [15:0] e;
            e = 16'h1000 + 16'(j * 16'h0111);
            send_frame(1'b1, '0, 1'b0, '0, 1'b0, got, dummy);
            check(got[63:48] == e, "R3 fifo order", got[63:48], e);
            wait_cycles(10);
            bus_read(1'b0, rv);
            check(rv[15:0] == e, "R6 loopback telecom", rv, e);
            bus_read(1'b1, rv);
        end
        check(tx_empty[0] == 1'b1, "R2 ninth write dropped", tx_empty, 2'b11);

        // R7 overrun: nine pushes into an 8-deep receive queue
        for (int j = 0; j < 9; j++) begin
            send_frame(1'b0, {16'h2000 + 16'(j), 16'h30F5 + 16'(j << 4), 32'h0}, 1'b0, '0, 1'b0, got, dummy);
            wait_cycles(10);
            if (j == 7) begin
                check(rx_full == 2'b11 && rx_overrun == 2'b00, "R7 full no overrun", {rx_full, rx_overrun}, 4'hC);
            end
        end
        check(rx_overrun == 2'b11, "R7 overrun flag", rx_overrun, 2'b11);
        for (int j = 0; j < 8; j++) begin
            logic [15:0] ea;
            ea = (16'h30F5 + 16'(j << 4)) & 16'hFFF0;
            bus_read(1'b0, rv);
            check(rv == 32'h2000 + 32'(j), "R7 kept entries telecom", rv, 32'h2000 + 32'(j));
            bus_read(1'b1, rv);
            check(rv == {16'h0, ea}, "R7 R9 kept entries audio", rv, {16'h0, ea});
        end
        check(rx_empty == 2'b11, "R7 ninth discarded", rx_empty, 2'b11);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule